// File: doc/BRIEF.md
# Register-Write Event Pulse Generator

This block turns stores into a processor's 32-bit output register into one-clock event pulses for a system interrupt controller. Each processing core supplies a write strobe and the 32-bit word it writes. A qualifying word carries a valid flag and a 4-bit channel number. The block decodes that channel into one of sixteen request lines and pulses that line for a single clock.

The decoded vectors of all cores are merged by a bitwise OR and registered. The result leaves the block in two forms. The first is a 16-bit event request bus. The second is the same 16 lines placed on lines 16 to 31 of a 64-line system event bus, with every other line held low. Firmware uses this to raise software interrupts towards a host or towards the other core. Channel-to-host mapping is done downstream of this block.

Top module: `evt_pulse_gen`

## Requirements
- R1: When a core's write strobe is high and bit 5 of its write word is 1, `evt_req[n]` is 1 in the cycle after the write, where n is bits 3..0 of the word (0x20 gives line 0, 0x2F gives line 15).
- R2: A write whose bit 5 is 0 produces no pulse on any line, whatever bits 3..0 hold.
- R3: Bit 4 and bits 31..6 of the write word have no effect on which line pulses or on whether any line pulses.
- R4: A qualifying write from one core, with no qualifying write from the other core, makes exactly one line of `evt_req` high.
- R5: A pulse lasts exactly one clock cycle. It does not repeat unless another qualifying write arrives.
- R6: Qualifying writes from both cores in the same cycle to different channels make both lines pulse together in the next cycle.
- R7: Qualifying writes from both cores in the same cycle to the same channel make a single one-cycle pulse on that line.
- R8: Qualifying writes on consecutive cycles produce pulses on consecutive cycles, with no suppression or merging across cycles.
- R9: `sys_evt[16+n]` equals `evt_req[n]` for n from 0 to 15, and every other line of `sys_evt` is 0.
- R10: While the synchronous active-high reset `rst` is high, all outputs are 0 and writes are ignored. No pulse appears in the cycle after reset is released, unless a qualifying write arrives in the release cycle.
- R11: A core whose write strobe is low causes no pulse, whatever its write word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 2 | Per-core write strobe for the output register; bit c belongs to core c |
| wr_data | input | 64 | Per-core write word; bits [32c+31:32c] belong to core c |
| evt_req | output | 16 | Registered event request pulses, one line per channel |
| sys_evt | output | 64 | System event bus; lines 16..31 carry `evt_req`, all others are 0 |

## Verification
Two cores can both post a qualifying write in the same cycle. That is the one point where the OR merge and the channel decode interact. The vector table contains rows where both strobes are high with the same channel, with different channels, and with one valid and one invalid word. Each row is judged by comparing the whole 16-bit request word and the whole 64-bit system bus, one cycle later, against a value built from the requirements. A missing line, an extra line, or a line that wrongly persists each shows up as a mismatch.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Default geometry of the output register word
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned VALID_POS = 5;
  localparam int unsigned CHAN_BITS = 4;

  // Default system event bus placement
  localparam int unsigned SYS_LINES = 64;
  localparam int unsigned SYS_FIRST = 16;

  // One-hot decode of a channel number, gated by an enable
  function automatic logic [(1<<CHAN_BITS)-1:0] chan_onehot(
    input logic                 en,
    input logic [CHAN_BITS-1:0] chan
  );
    logic [(1<<CHAN_BITS)-1:0] v;
    v = '0;
    if (en) v[chan] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/evt_core_decode.sv
module evt_core_decode #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned VALID_BIT = 5,
  parameter int unsigned CHAN_W    = 4,
  localparam int unsigned LINES    = 1 << CHAN_W
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINES-1:0]  hit
);

  logic              fire;
  logic [CHAN_W-1:0] chan;
  logic              unused_rsvd;

  assign fire = wr_en & wr_data[VALID_BIT];
  assign chan = wr_data[CHAN_W-1:0];

  // Reserved bits play no part in the decode
  assign unused_rsvd = ^wr_data;

  always_comb begin
    hit = '0;
    if (fire) hit[chan] = 1'b1;
  end

endmodule

// File: rtl/evt_merge_reg.sv
module evt_merge_reg #(
  parameter int unsigned CORES = 2,
  parameter int unsigned LINES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CORES*LINES-1:0] hits,
  output logic [LINES-1:0]       evt_q
);

  logic [LINES-1:0] merged;

  always_comb begin
    merged = '0;
    for (int c = 0; c < CORES; c++) begin
      merged = merged | hits[c*LINES +: LINES];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= merged;
  end

endmodule

// File: rtl/evt_sys_place.sv
module evt_sys_place #(
  parameter int unsigned LINES     = 16,
  parameter int unsigned SYS_W     = 64,
  parameter int unsigned SYS_BASE  = 16
) (
  input  logic [LINES-1:0] evt,
  output logic [SYS_W-1:0] sys
);

  for (genvar i = 0; i < SYS_W; i++) begin : g_line
    if (i >= SYS_BASE && i < SYS_BASE + LINES) begin : g_map
      assign sys[i] = evt[i - SYS_BASE];
    end else begin : g_zero
      assign sys[i] = 1'b0;
    end
  end

endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen #(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned DATA_W    = evt_pkg::WORD_W,
  parameter int unsigned VALID_BIT = evt_pkg::VALID_POS,
  parameter int unsigned CHAN_W    = evt_pkg::CHAN_BITS,
  parameter int unsigned SYS_W     = evt_pkg::SYS_LINES,
  parameter int unsigned SYS_BASE  = evt_pkg::SYS_FIRST,
  localparam int unsigned LINES    = 1 << CHAN_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES-1:0]        wr_en,
  input  logic [NUM_CORES*DATA_W-1:0] wr_data,
  output logic [LINES-1:0]            evt_req,
  output logic [SYS_W-1:0]            sys_evt
);

  logic [NUM_CORES*LINES-1:0] core_hits;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    evt_core_decode #(
      .DATA_W    (DATA_W),
      .VALID_BIT (VALID_BIT),
      .CHAN_W    (CHAN_W)
    ) u_dec (
      .wr_en   (wr_en[c]),
      .wr_data (wr_data[c*DATA_W +: DATA_W]),
      .hit     (core_hits[c*LINES +: LINES])
    );
  end

  evt_merge_reg #(
    .CORES (NUM_CORES),
    .LINES (LINES)
  ) u_merge (
    .clk   (clk),
    .rst   (rst),
    .hits  (core_hits),
    .evt_q (evt_req)
  );

  evt_sys_place #(
    .LINES    (LINES),
    .SYS_W    (SYS_W),
    .SYS_BASE (SYS_BASE)
  ) u_place (
    .evt (evt_req),
    .sys (sys_evt)
  );

endmodule

// File: rtl/evt_pulse_gen_chk.sv
module evt_pulse_gen_chk #(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned VALID_BIT = 5,
  parameter int unsigned CHAN_W    = 4,
  localparam int unsigned LINES    = 1 << CHAN_W
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CORES-1:0]        wr_en,
  input logic [NUM_CORES*DATA_W-1:0] wr_data,
  input logic [LINES-1:0]            evt_req
);

  logic [NUM_CORES-1:0] fire_now;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_fire
    assign fire_now[c] = wr_en[c] & wr_data[c*DATA_W + VALID_BIT];

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      fire_now[c] |=> evt_req[$past(wr_data[c*DATA_W +: CHAN_W])]);  // R1
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (evt_req == '0));  // R10

  AST_NO_FIRE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fire_now == '0) |=> (evt_req == '0));  // R2

  AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (rst)
    ($countones(fire_now) == 1) |=> ($countones(evt_req) == 1));  // R4

endmodule

bind evt_pulse_gen evt_pulse_gen_chk #(
  .NUM_CORES (NUM_CORES),
  .DATA_W    (DATA_W),
  .VALID_BIT (VALID_BIT),
  .CHAN_W    (CHAN_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .evt_req (evt_req)
);

// File: tb/sim_evt_pulse_gen.sv
`timescale 1ns/1ps
module sim_evt_pulse_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  wr_en = '0;
  logic [63:0] wr_data = '0;
  logic [15:0] evt_req;
  logic [63:0] sys_evt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  evt_pulse_gen u0 (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .evt_req (evt_req),
    .sys_evt (sys_evt)
  );

  // Row: {en0, en1, data0, data1, expected evt_req}
  localparam int NV = 13;
  localparam logic [81:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'h0000_0020, 32'h0000_0000, 16'h0001},  // R1 line 0
    {1'b1, 1'b0, 32'h0000_002F, 32'h0000_0000, 16'h8000},  // R1 R8 line 15
    {1'b1, 1'b0, 32'h0000_001F, 32'h0000_0000, 16'h0000},  // R2
    {1'b1, 1'b1, 32'hFFFF_FFDF, 32'hFFFF_FFDA, 16'h0000},  // R2 R3
    {1'b1, 1'b0, 32'hFFFF_FFF5, 32'h0000_0000, 16'h0020},  // R3 R4
    {1'b0, 1'b1, 32'h0000_0000, 32'h0000_0023, 16'h0008},  // R1 core 1
    {1'b1, 1'b1, 32'h0000_0021, 32'h0000_002A, 16'h0402},  // R6
    {1'b1, 1'b1, 32'h0000_0027, 32'h0000_0027, 16'h0080},  // R7
    {1'b0, 1'b0, 32'h0000_0020, 32'h0000_002C, 16'h0000},  // R11
    {1'b1, 1'b1, 32'h0000_0020, 32'h0000_000F, 16'h0001},  // R2 mixed
    {1'b0, 1'b1, 32'h0000_0000, 32'hAAAA_AA3C, 16'h1000},  // R3
    {1'b1, 1'b1, 32'h0000_0039, 32'h0000_0036, 16'h0240},  // R6 R3
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 16'h0000}   // R5
  };

  task automatic check(input string tag, input logic [15:0] exp);
    logic [63:0] exp_sys;
    exp_sys = {32'h0, exp, 16'h0};
    checks++;
    if (evt_req !== exp) begin
      errors++;
      $display("FAIL %s evt_req actual %h expected %h", tag, evt_req, exp);
    end
    checks++;
    if (sys_evt !== exp_sys) begin
      errors++;
      $display("FAIL %s/R9 sys_evt actual %h expected %h", tag, sys_evt, exp_sys);
    end
  endtask

  task automatic drive(input logic e0, input logic e1,
                       input logic [31:0] d0, input logic [31:0] d1);
    wr_en   = {e1, e0};
    wr_data = {d1, d0};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: writes during reset are ignored, outputs stay clear
    @(negedge clk);
    drive(1'b1, 1'b1, 32'h0000_0025, 32'h0000_002E);
    @(posedge clk); @(negedge clk);
    check("R10 reset", 16'h0000);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 release", 16'h0000);

    // Vector table, one row per cycle, so rows run back to back (R8)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][81], VEC[i][80], VEC[i][79:48], VEC[i][47:16]);
      @(posedge clk); @(negedge clk);
      check($sformatf("R1 row %0d", i), VEC[i][15:0]);
    end

    // R5: single write, pulse lasts one cycle only
    drive(1'b1, 1'b0, 32'h0000_0029, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R5 pulse", 16'h0200);
    drive(1'b0, 1'b0, 32'h0000_0029, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R5 gone", 16'h0000);

    // R8: same channel on consecutive cycles gives two pulses
    drive(1'b1, 1'b0, 32'h0000_0024, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 first", 16'h0010);
    @(posedge clk); @(negedge clk);
    check("R8 second", 16'h0010);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8 end", 16'h0000);

    // R10: reset asserted mid-pulse clears the output
    drive(1'b0, 1'b1, 32'h0, 32'h0000_002B);
    @(posedge clk); @(negedge clk);
    check("R10 pre", 16'h0800);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10 mid", 16'h0000);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 after", 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule